// File: doc/BRIEF.md
# Receive Mailbox Identifier Matcher

This block places frames from a CAN-style protocol engine into a small bank of receive mailboxes. The engine offers each frame (identifier, format bit, length and eight data bytes) on a valid/ready stream when it reaches the CRC field. At that moment the block looks for a matching mailbox and chooses one. When the engine later reports that the frame ended without error, the block writes the frame into the chosen mailbox. It also stamps the mailbox with the free-running timer, advances the mailbox status code and sets that mailbox's flag. The interrupt line rises if the flag is unmasked. When the engine reports an error instead, the pending frame is dropped.

A CPU port writes and reads the per-mailbox control and identifier words, and the global flag and mask words. To arm a mailbox, software writes the control word with the inactive code, then optionally writes the identifier, then writes the empty code.

Stream rules: a frame is taken on a clock edge where `frm_valid` and `frm_ready` are both high. After that, `frm_ready` stays low until the engine pulses `end_ok` or `end_err`. A producer that holds `frm_valid` high while `frm_ready` is low simply waits. Its fields must stay stable until the frame is taken. Pulses on `end_ok` or `end_err` while nothing is pending are ignored.

Top module: `rx_mbox_match`

## Requirements
- R1: After reset, every mailbox word reads zero (code 0000, inactive), flags and mask are zero, `irq` is low and `frm_ready` is high.
- R2: A mailbox whose code is neither 0100 (empty), 0010 (full) nor 0110 (overrun), including 0000 (inactive) and undefined values such as 1000, never receives a frame.
- R3: Mailboxes with code empty, full or overrun take part. On move-in, empty becomes full, and full or overrun becomes overrun.
- R4: When several mailboxes match, only the lowest-index one receives the frame, and at most one flag is newly set per frame.
- R5: A match needs equal format bits. Standard frames (format 0) compare identifier bits 10:0 only, and extended frames (format 1) compare all 29 bits, so the two formats never match each other.
- R6: On move-in, the mailbox stores the frame's identifier, format bit, 4-bit length (stored as given, even above 8) and 64 data bits. It also stores the timer value sampled at the `end_ok` edge. Read layout: select 0 gives the control word {timestamp[31:16], length[11:8], code[3:0]}; select 1 gives {format[31], identifier[28:0]}; selects 2 and 3 give data bits 31:0 and 63:32, with byte 0 in bits 7:0.
- R7: When the engine pulses `end_err`, or when no mailbox matches, no mailbox and no flag changes.
- R8: A move-in sets that mailbox's flag. Writing select 4 clears each flag whose data bit is 1. A set and a clear of the same flag in one cycle leave it set.
- R9: `irq` is high exactly when some flag and its mask bit (select 5) are both 1.
- R10: `frm_ready` falls on the edge after a frame is taken and rises on the edge after `end_ok` or `end_err`.
- R11: The chosen mailbox does not receive the frame in two cases: its code is no longer empty, full or overrun at the `end_ok` edge, or the CPU writes its control word in that same cycle. In the second case the CPU value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_valid | input | 1 | Frame offered at its CRC field |
| frm_ready | output | 1 | Block can take a frame |
| frm_ide | input | 1 | Frame format, 1 = extended |
| frm_id | input | 29 | Frame identifier |
| frm_len | input | 4 | Frame length field |
| frm_data | input | 64 | Frame data, byte 0 in bits 7:0 |
| end_ok | input | 1 | Pending frame completed without error |
| end_err | input | 1 | Pending frame failed |
| timer | input | 16 | Free-running timer value |
| cpu_we | input | 1 | CPU write strobe |
| cpu_addr | input | 2 | Mailbox index |
| cpu_sel | input | 3 | Word select: 0 ctrl, 1 id, 2 data low, 3 data high, 4 flags, 5 mask |
| cpu_wdata | input | 32 | CPU write data |
| cpu_rdata | output | 32 | CPU read data (combinational) |
| flags | output | 4 | Per-mailbox receive flags |
| irq | output | 1 | Masked interrupt |

## Verification
Two activities can land on the same clock edge: the move-in triggered by `end_ok`, and a CPU write that touches the same state.

The bench provokes two such collisions. In the first, it clears a mailbox's flag in the very cycle that mailbox receives a new frame; the flag must stay set while other cleared bits drop. In the second, it writes the control word of the chosen mailbox during the `end_ok` cycle; the mailbox must then hold the CPU's code with no new data or flag.

Around these cases, a sweep covers all code combinations across four mailboxes, with both formats and overlapping identifiers. Each result is compared against a reference model kept in the bench.

// File: rtl/rxm_pkg.sv
package rxm_pkg;
  localparam logic [3:0] CODE_INACTIVE = 4'b0000;
  localparam logic [3:0] CODE_EMPTY    = 4'b0100;
  localparam logic [3:0] CODE_FULL     = 4'b0010;
  localparam logic [3:0] CODE_OVERRUN  = 4'b0110;

  localparam logic [2:0] SEL_CTRL = 3'd0;
  localparam logic [2:0] SEL_ID   = 3'd1;
  localparam logic [2:0] SEL_DLO  = 3'd2;
  localparam logic [2:0] SEL_DHI  = 3'd3;
  localparam logic [2:0] SEL_FLAG = 3'd4;
  localparam logic [2:0] SEL_MASK = 3'd5;

  typedef struct packed {
    logic        ide;
    logic [28:0] id;
    logic [3:0]  len;
    logic [63:0] data;
  } rx_frame_t;

  function automatic logic code_takes_part(logic [3:0] c);
    return (c == CODE_EMPTY) || (c == CODE_FULL) || (c == CODE_OVERRUN);
  endfunction

  function automatic logic [3:0] code_after_fill(logic [3:0] c);
    return (c == CODE_EMPTY) ? CODE_FULL : CODE_OVERRUN;
  endfunction

  function automatic logic [28:0] norm_id(logic ide, logic [28:0] id);
    return ide ? id : {18'd0, id[10:0]};
  endfunction
endpackage

// File: rtl/rxm_match.sv
module rxm_match
  import rxm_pkg::*;
#(
  parameter int NUM_MB = 4,
  parameter int IDX_W  = 2
) (
  input  logic [3:0]       code  [NUM_MB],
  input  logic             mb_ide[NUM_MB],
  input  logic [28:0]      mb_id [NUM_MB],
  input  logic             f_ide,
  input  logic [28:0]      f_id,
  output logic             hit,
  output logic [IDX_W-1:0] win
);
  logic [NUM_MB-1:0] cand;
  logic [28:0]       key;

  assign key = norm_id(f_ide, f_id);

  for (genvar g = 0; g < NUM_MB; g++) begin : g_cmp
    assign cand[g] = code_takes_part(code[g]) && (mb_ide[g] == f_ide) && (mb_id[g] == key);
  end

  always_comb begin
    hit = |cand;
    win = '0;
    for (int i = NUM_MB - 1; i >= 0; i--) begin
      if (cand[i]) win = IDX_W'(i);
    end
  end
endmodule

// File: rtl/rxm_mailbox.sv
module rxm_mailbox
  import rxm_pkg::*;
#(
  parameter int TS_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ctrl_we,
  input  logic            id_we,
  input  logic [31:0]     wdata,
  input  logic            fill,
  input  rx_frame_t       frm,
  input  logic [TS_W-1:0] stamp,
  output logic [3:0]      code,
  output logic            ide,
  output logic [28:0]     id,
  output logic [3:0]      len,
  output logic [63:0]     data,
  output logic [TS_W-1:0] ts
);
  always_ff @(posedge clk) begin
    if (rst) begin
      code <= CODE_INACTIVE;
      ide  <= 1'b0;
      id   <= '0;
      len  <= '0;
      data <= '0;
      ts   <= '0;
    end else begin
      if (ctrl_we)   code <= wdata[3:0];
      else if (fill) code <= code_after_fill(code);
      if (fill) begin
        ide  <= frm.ide;
        id   <= frm.id;
        len  <= frm.len;
        data <= frm.data;
        ts   <= stamp;
      end else if (id_we) begin
        ide <= wdata[31];
        id  <= norm_id(wdata[31], wdata[28:0]);
      end
    end
  end
endmodule

// File: rtl/rx_mbox_match.sv
module rx_mbox_match
  import rxm_pkg::*;
#(
  parameter int NUM_MB = 4,
  parameter int TS_W   = 16,
  parameter int IDX_W  = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frm_valid,
  output logic              frm_ready,
  input  logic              frm_ide,
  input  logic [28:0]       frm_id,
  input  logic [3:0]        frm_len,
  input  logic [63:0]       frm_data,
  input  logic              end_ok,
  input  logic              end_err,
  input  logic [TS_W-1:0]   timer,
  input  logic              cpu_we,
  input  logic [IDX_W-1:0]  cpu_addr,
  input  logic [2:0]        cpu_sel,
  input  logic [31:0]       cpu_wdata,
  output logic [31:0]       cpu_rdata,
  output logic [NUM_MB-1:0] flags,
  output logic              irq
);
  logic [3:0]      mb_code [NUM_MB];
  logic            mb_ide  [NUM_MB];
  logic [28:0]     mb_id   [NUM_MB];
  logic [3:0]      mb_len  [NUM_MB];
  logic [63:0]     mb_data [NUM_MB];
  logic [TS_W-1:0] mb_ts   [NUM_MB];

  logic              pend_vld, pend_hit;
  logic [IDX_W-1:0]  pend_win;
  rx_frame_t         pend_frm;
  logic              m_hit;
  logic [IDX_W-1:0]  m_win;
  logic              take, commit, ctrl_hit_win;
  logic [NUM_MB-1:0] flag_q, mask_q, fill_vec, clr_vec;

  assign frm_ready = !pend_vld;
  assign take      = frm_valid && frm_ready;

  rxm_match #(.NUM_MB(NUM_MB), .IDX_W(IDX_W)) u_match (
    .code(mb_code), .mb_ide(mb_ide), .mb_id(mb_id),
    .f_ide(frm_ide), .f_id(frm_id), .hit(m_hit), .win(m_win)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_vld <= 1'b0;
      pend_hit <= 1'b0;
      pend_win <= '0;
      pend_frm <= '0;
    end else if (take) begin
      pend_vld      <= 1'b1;
      pend_hit      <= m_hit;
      pend_win      <= m_win;
      pend_frm.ide  <= frm_ide;
      pend_frm.id   <= norm_id(frm_ide, frm_id);
      pend_frm.len  <= frm_len;
      pend_frm.data <= frm_data;
    end else if (pend_vld && (end_ok || end_err)) begin
      pend_vld <= 1'b0;
    end
  end

  assign ctrl_hit_win = cpu_we && (cpu_sel == SEL_CTRL) && (cpu_addr == pend_win);
  assign commit = pend_vld && end_ok && pend_hit && !ctrl_hit_win &&
                  code_takes_part(mb_code[pend_win]);

  for (genvar g = 0; g < NUM_MB; g++) begin : g_mb
    assign fill_vec[g] = commit && (pend_win == IDX_W'(g));
    rxm_mailbox #(.TS_W(TS_W)) u_mb (
      .clk(clk), .rst(rst),
      .ctrl_we(cpu_we && cpu_sel == SEL_CTRL && cpu_addr == IDX_W'(g)),
      .id_we(cpu_we && cpu_sel == SEL_ID && cpu_addr == IDX_W'(g)),
      .wdata(cpu_wdata), .fill(fill_vec[g]), .frm(pend_frm), .stamp(timer),
      .code(mb_code[g]), .ide(mb_ide[g]), .id(mb_id[g]),
      .len(mb_len[g]), .data(mb_data[g]), .ts(mb_ts[g])
    );
  end

  assign clr_vec = (cpu_we && cpu_sel == SEL_FLAG) ? cpu_wdata[NUM_MB-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      mask_q <= '0;
    end else begin
      flag_q <= (flag_q & ~clr_vec) | fill_vec;
      if (cpu_we && cpu_sel == SEL_MASK) mask_q <= cpu_wdata[NUM_MB-1:0];
    end
  end

  assign flags = flag_q;
  assign irq   = |(flag_q & mask_q);

  always_comb begin
    cpu_rdata = '0;
    case (cpu_sel)
      SEL_CTRL: begin
        cpu_rdata[3:0]       = mb_code[cpu_addr];
        cpu_rdata[11:8]      = mb_len[cpu_addr];
        cpu_rdata[16 +: TS_W] = mb_ts[cpu_addr];
      end
      SEL_ID:   cpu_rdata = {mb_ide[cpu_addr], 2'b00, mb_id[cpu_addr]};
      SEL_DLO:  cpu_rdata = mb_data[cpu_addr][31:0];
      SEL_DHI:  cpu_rdata = mb_data[cpu_addr][63:32];
      SEL_FLAG: cpu_rdata[NUM_MB-1:0] = flag_q;
      SEL_MASK: cpu_rdata[NUM_MB-1:0] = mask_q;
      default:  cpu_rdata = '0;
    endcase
  end
endmodule

// File: rtl/rxm_checker.sv
module rxm_checker #(
  parameter int NUM_MB = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              frm_valid,
  input logic              frm_ready,
  input logic              end_ok,
  input logic              end_err,
  input logic              pend_vld,
  input logic [NUM_MB-1:0] flags,
  input logic [NUM_MB-1:0] mask,
  input logic              irq
);
  assert_ready_drop_R10: assert property (@(posedge clk) disable iff (rst)
    (frm_valid && frm_ready) |=> !frm_ready);

  assert_flag_source_R8: assert property (@(posedge clk) disable iff (rst)
    ((flags & ~$past(flags)) != '0) |-> $past(end_ok && pend_vld));

  assert_single_winner_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(flags & ~$past(flags)));

  assert_err_no_flag_R7: assert property (@(posedge clk) disable iff (rst)
    $past(end_err && !end_ok) |-> ((flags & ~$past(flags)) == '0));

  assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (rst)
    irq |-> ((flags & mask) != '0));
endmodule

bind rx_mbox_match rxm_checker #(.NUM_MB(NUM_MB)) u_chk (
  .clk(clk), .rst(rst), .frm_valid(frm_valid), .frm_ready(frm_ready),
  .end_ok(end_ok), .end_err(end_err), .pend_vld(pend_vld),
  .flags(flags), .mask(mask_q), .irq(irq)
);

// File: tb/rx_mbox_match_tb.sv
module rx_mbox_match_tb;
  localparam logic [3:0] EMP = 4'b0100, FUL = 4'b0010, OVR = 4'b0110, INA = 4'b0000;

  logic clk = 1'b0, rst = 1'b1;
  logic frm_valid = 0, frm_ready, frm_ide = 0, end_ok = 0, end_err = 0, cpu_we = 0, irq;
  logic [28:0] frm_id = '0;
  logic [3:0]  frm_len = '0;
  logic [63:0] frm_data = '0;
  logic [15:0] tmr = 16'h0100;
  logic [1:0]  cpu_addr = '0;
  logic [2:0]  cpu_sel = '0;
  logic [31:0] cpu_wdata = '0, cpu_rdata;
  logic [3:0]  flags;

  int nvec = 0, nbad = 0;
  bit finished = 0;

  logic [3:0]  m_code[4];
  logic        m_ide[4];
  logic [28:0] m_id[4];
  logic [3:0]  m_len[4];
  logic [63:0] m_data[4];
  logic [15:0] m_ts[4];
  logic [3:0]  m_flag = '0, m_mask = '0;

  always #10 clk = ~clk;
  always @(posedge clk) tmr <= tmr + 16'd3;

  rx_mbox_match u_dut (
    .clk(clk), .rst(rst), .frm_valid(frm_valid), .frm_ready(frm_ready),
    .frm_ide(frm_ide), .frm_id(frm_id), .frm_len(frm_len), .frm_data(frm_data),
    .end_ok(end_ok), .end_err(end_err), .timer(tmr), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_sel(cpu_sel), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .flags(flags), .irq(irq)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic part(logic [3:0] c);
    return c == EMP || c == FUL || c == OVR;
  endfunction

  function automatic logic [28:0] nid(logic ide, logic [28:0] id);
    return ide ? id : {18'd0, id[10:0]};
  endfunction

  task automatic wr(int a, logic [2:0] s, logic [31:0] d);
    @(negedge clk);
    cpu_we = 1; cpu_addr = 2'(a); cpu_sel = s; cpu_wdata = d;
    @(negedge clk);
    cpu_we = 0;
    if (s == 3'd0) m_code[a] = d[3:0];
    if (s == 3'd1) begin m_ide[a] = d[31]; m_id[a] = nid(d[31], d[28:0]); end
    if (s == 3'd4) m_flag = m_flag & ~d[3:0];
    if (s == 3'd5) m_mask = d[3:0];
  endtask

  task automatic rd(int a, logic [2:0] s, output logic [31:0] v);
    cpu_addr = 2'(a); cpu_sel = s; #1; v = cpu_rdata;
  endtask

  task automatic check_all(string tag);
    logic [31:0] v;
    for (int i = 0; i < 4; i++) begin
      rd(i, 3'd0, v); chk({tag, " R3 R6 ctrl"}, 64'(v), 64'({m_ts[i], 4'h0, m_len[i], 4'h0, m_code[i]}));
      rd(i, 3'd1, v); chk({tag, " R5 R6 id"}, 64'(v), 64'({m_ide[i], 2'b00, m_id[i]}));
      rd(i, 3'd2, v); chk({tag, " R6 dlo"}, 64'(v), 64'(m_data[i][31:0]));
      rd(i, 3'd3, v); chk({tag, " R6 dhi"}, 64'(v), 64'(m_data[i][63:32]));
    end
    chk({tag, " R4 R8 flags"}, 64'(flags), 64'(m_flag));
    chk({tag, " R9 irq"}, 64'(irq), 64'(|(m_flag & m_mask)));
  endtask

  // coll: 0 none, 1 ctrl write to coll_a, 2 flag clear with coll_d
  task automatic frame(logic ide, logic [28:0] id, logic [3:0] len, logic [63:0] d,
                       bit ok, int coll, int coll_a, logic [31:0] coll_d);
    bit hit = 0; int w = 0; logic [15:0] st; bit go;
    for (int i = 3; i >= 0; i--)
      if (part(m_code[i]) && m_ide[i] == ide && m_id[i] == nid(ide, id)) begin hit = 1; w = i; end
    @(negedge clk);
    frm_valid = 1; frm_ide = ide; frm_id = id; frm_len = len; frm_data = d;
    @(negedge clk);
    frm_valid = 0;
    chk("R10 ready low while pending", 64'(frm_ready), 64'(0));
    end_ok = ok; end_err = !ok;
    if (coll == 1) begin cpu_we = 1; cpu_sel = 3'd0; cpu_addr = 2'(coll_a); cpu_wdata = coll_d; end
    if (coll == 2) begin cpu_we = 1; cpu_sel = 3'd4; cpu_wdata = coll_d; end
    st = tmr;
    @(negedge clk);
    end_ok = 0; end_err = 0; cpu_we = 0;
    go = ok && hit && part(m_code[w]) && !(coll == 1 && coll_a == w);
    if (coll == 1) m_code[coll_a] = coll_d[3:0];
    if (coll == 2) m_flag = m_flag & ~coll_d[3:0];
    if (go) begin
      m_code[w] = (m_code[w] == EMP) ? FUL : OVR;
      m_ide[w] = ide; m_id[w] = nid(ide, id); m_len[w] = len; m_data[w] = d; m_ts[w] = st;
      m_flag[w] = 1'b1;
    end
    chk("R10 ready back", 64'(frm_ready), 64'(1));
  endtask

  function automatic logic [3:0] code_of(int k);
    case (k & 3) 0: return INA; 1: return EMP; 2: return FUL; default: return OVR;
    endcase
  endfunction

  initial begin
    for (int i = 0; i < 4; i++) begin
      m_code[i] = 0; m_ide[i] = 0; m_id[i] = 0; m_len[i] = 0; m_data[i] = 0; m_ts[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    chk("R1 ready", 64'(frm_ready), 64'(1));
    check_all("R1 reset");

    // sweep: mb0 A std, mb1 B std, mb2 A ext, mb3 A std
    for (int q = 0; q < 1024; q++) begin
      logic [28:0] fid;
      logic [31:0] ids[4];
      ids[0] = 32'h0000_0123; ids[1] = 32'h0000_0456;
      ids[2] = 32'h8000_0123; ids[3] = 32'h0000_0123;
      wr(0, 3'd4, 32'hF);
      wr(0, 3'd5, 32'(4'(q) ^ 4'(q >> 4)));
      for (int i = 0; i < 4; i++) begin
        wr(i, 3'd0, 32'(INA));
        wr(i, 3'd1, ids[i] | ((q & 1) ? 32'h0001_F800 : 32'h0));
        wr(i, 3'd0, 32'(code_of(q >> (2 * i))));
      end
      fid = q[8] ? 29'h456 : 29'h123;
      if (q[9] && q[8]) fid = 29'h1ABC_0123;
      frame(q[9], fid | ((q & 2) ? 29'h0000_F800 : 29'h0), 4'(q * 5),
            {16'hC0DE, 16'(q), 16'(~q), 16'(q * 7)}, (q % 5) != 4, 0, 0, 0);
      check_all("R2 R3 R4 R5 R7 sweep");
    end

    // R2: undefined codes never receive
    wr(0, 3'd4, 32'hF);
    wr(0, 3'd0, 32'h8); wr(0, 3'd1, 32'h77);
    wr(1, 3'd0, 32'hF); wr(1, 3'd1, 32'h77);
    wr(2, 3'd0, 32'h0); wr(2, 3'd1, 32'h77);
    wr(3, 3'd0, 32'(EMP)); wr(3, 3'd1, 32'h77);
    frame(0, 29'h77, 4'd8, 64'h1122334455667788, 1, 0, 0, 0);
    check_all("R2 undefined codes");

    // R11: ctrl write to winner in end cycle cancels move-in
    wr(0, 3'd0, 32'(EMP)); wr(0, 3'd4, 32'hF);
    frame(0, 29'h77, 4'd3, 64'hDEAD_BEEF_0000_0001, 1, 1, 0, 32'(FUL));
    check_all("R11 ctrl collision");
    // R11: deactivated after CRC -> no move-in (set inactive during pending)
    wr(0, 3'd0, 32'(EMP));
    frame(0, 29'h77, 4'd2, 64'h5, 1, 1, 0, 32'(INA));
    check_all("R11 deactivate collision");

    // R8: flag clear same cycle as set keeps flag; others clear
    wr(0, 3'd5, 32'hF);
    frame(0, 29'h77, 4'd1, 64'h9, 1, 0, 0, 0);   // mb3 gets flag
    wr(1, 3'd0, 32'(EMP));
    frame(0, 29'h77, 4'd4, 64'hAB, 1, 2, 0, 32'hF); // mb1 set while clearing all
    check_all("R8 set beats clear");
    wr(0, 3'd4, 32'h2);
    check_all("R8 R9 w1c");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nvec++; nbad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule